// File: doc/BRIEF.md
# I2C Write Target with Acknowledge Stretching

This block is the receive side of an I2C target on an open-drain bus. Each of the two bus lines comes in as a sampled level and goes out as a pull-low enable. The block never drives a line high: a high level comes from releasing the line. The bus inputs are resynchronised to the system clock, which runs much faster than SCL. Bus edges are then found on the resynchronised levels.

After a START, the block shifts in an address byte. It acknowledges the address only when the seven address bits match the configured address and the direction bit is a write. From then on, every data byte of the transfer is acknowledged and handed to the core as a one-cycle valid pulse with the byte beside it.

The core decides when each acknowledge is given through a ready input. If the core is not ready when an acknowledge slot opens, the block holds SCL low until ready arrives. It then pulls SDA low and lets the clock go.

Top module: `i2c_rx_target`

## Requirements
- R1: During and right after reset, scl_oe, sda_oe and rx_valid are 0 and rx_data is 0.
- R2: A START is a falling SDA while SCL is high; it begins address reception. A STOP is a rising SDA while SCL is high; after it, both drive enables are 0 and no byte is acknowledged until the next START.
- R3: Bits are taken on rising SCL edges. The first bit received is bit 7 of the byte (MSB first), so 0x01 and 0x80 are received as distinct values.
- R4: The address byte is acknowledged when its bits 7..1 equal own_addr and its bit 0 (direction) is 0. To acknowledge, the block pulls SDA low while SCL is low, holds it through the ninth SCL pulse, and releases it on the falling SCL edge that ends that pulse.
- R5: When the address does not match, or its bit 0 is 1, SDA and SCL are never driven for the rest of the transfer. Later bytes are neither acknowledged nor presented.
- R6: When an acknowledge is due and ack_ready is 0 after the falling edge that ends the eighth bit, SCL is held low and SDA is released. When ack_ready becomes 1, SCL is released and SDA is driven low in the same cycle.
- R7: If ack_ready is already 1 when the acknowledge slot opens, SCL is never driven.
- R8: Each data byte after an acknowledged address is acknowledged. It appears on rx_data with a single-cycle rx_valid pulse at the rising edge of the ninth SCL pulse.
- R9: A START in the middle of a byte (repeated START) discards the partial byte without a valid pulse and restarts address reception.
- R10: rx_data keeps the last presented byte until the next rx_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretching) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| own_addr | input | 7 | Configured 7-bit target address |
| ack_ready | input | 1 | Core permits the pending acknowledge |
| rx_valid | output | 1 | One-cycle pulse for a received data byte |
| rx_data | output | 8 | Last received data byte |

## Verification
The hardest state to reach is a stretched acknowledge slot. To get there, the core must withhold ready exactly while a master that honours stretching has released SCL and waits for the line to rise. The bench's master waits on the wired-AND SCL level and not on its own drive. A parallel thread drops ack_ready before a data byte, waits until the block pulls SCL low, and holds the slot for a hundred cycles. It then checks that SCL is still held and SDA is still released, and only after that raises ready. A repeated START placed four bits into a byte covers the abort path.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  // Address byte selects this target for a write transfer
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [ADDR_W-1:0] own);
    return (b[BYTE_W-1:1] == own) && !b[0];
  endfunction
endpackage

// File: rtl/i2c_tgt_line_sync.sv
module i2c_tgt_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/i2c_tgt_cond_detect.sv
module i2c_tgt_cond_detect (
  input  logic scl_lvl,
  input  logic scl_rise,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_steady_hi;
  assign scl_steady_hi = scl_lvl & ~scl_rise;
  assign start_ev      = scl_steady_hi & sda_fall;
  assign stop_ev       = scl_steady_hi & sda_rise;
endmodule

// File: rtl/i2c_tgt_byte_shifter.sv
module i2c_tgt_byte_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] data,
  output logic         full
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      data <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (shift_en) begin
      cnt  <= cnt + 1'b1;
      data <= {data[W-2:0], bit_in};
    end
  end

  assign full = (cnt == LAST);
endmodule

// File: rtl/i2c_rx_target.sv
module i2c_rx_target
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_ready,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_in, line_lvl, line_rise, line_fall;
  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    i2c_tgt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(line_in[g]),
      .level(line_lvl[g]), .rise(line_rise[g]), .fall(line_fall[g])
    );
  end

  // Named bus events, visible to the checker
  logic scl_lvl, scl_rise, scl_fall, sda_lvl;
  logic start_ev, stop_ev;
  assign scl_lvl  = line_lvl[0];
  assign scl_rise = line_rise[0];
  assign scl_fall = line_fall[0];
  assign sda_lvl  = line_lvl[1];

  i2c_tgt_cond_detect u_cond (
    .scl_lvl(scl_lvl), .scl_rise(scl_rise),
    .sda_rise(line_rise[1]), .sda_fall(line_fall[1]),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  logic busy, first_byte, addressed, ack_phase, decided, want_ack, sda_drv;
  logic byte_full, shift_en, shr_clear;
  logic [BYTE_W-1:0] shr_data;
  logic ack_entry, ack_rise, ack_exit, entry_want;

  assign ack_entry  = busy & byte_full & ~ack_phase & scl_fall;
  assign ack_rise   = ack_phase & scl_rise;
  assign ack_exit   = ack_phase & scl_fall;
  assign entry_want = first_byte ? addr_hit(shr_data, own_addr) : addressed;
  assign shift_en   = busy & scl_rise & ~byte_full & ~ack_phase;
  assign shr_clear  = start_ev | stop_ev | ack_exit;

  i2c_tgt_byte_shifter #(.W(BYTE_W)) u_shr (
    .clk(clk), .rst_n(rst_n), .clear(shr_clear), .shift_en(shift_en),
    .bit_in(sda_lvl), .data(shr_data), .full(byte_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; first_byte <= 1'b0; addressed <= 1'b0;
      ack_phase <= 1'b0; decided <= 1'b0; want_ack <= 1'b0;
      sda_drv <= 1'b0; rx_valid <= 1'b0; rx_data <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (start_ev || stop_ev) begin
        busy <= start_ev; first_byte <= start_ev; addressed <= 1'b0;
        ack_phase <= 1'b0; decided <= 1'b0; want_ack <= 1'b0;
        sda_drv <= 1'b0;
      end else begin
        if (ack_phase && !decided && ack_ready) begin
          decided <= 1'b1;
          sda_drv <= 1'b1;
        end
        if (ack_entry) begin
          ack_phase <= 1'b1;
          want_ack  <= entry_want;
          decided   <= ~entry_want | ack_ready;
          sda_drv   <= entry_want & ack_ready;
        end
        if (ack_rise) begin
          if (first_byte) begin
            addressed  <= want_ack;
            busy       <= want_ack;
            first_byte <= 1'b0;
          end else if (addressed) begin
            rx_valid <= 1'b1;
            rx_data  <= shr_data;
          end
        end
        if (ack_exit) begin
          ack_phase <= 1'b0; decided <= 1'b0; want_ack <= 1'b0;
          sda_drv <= 1'b0;
        end
      end
    end
  end

  assign scl_oe = ack_phase & want_ack & ~decided;
  assign sda_oe = sda_drv;
endmodule

// File: rtl/i2c_rx_target_chk.sv
module i2c_rx_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic ack_ready,
  input logic rx_valid,
  input logic scl_rise_w,
  input logic scl_fall_w,
  input logic start_w,
  input logic stop_w
);
  p_idle_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> (!scl_oe && !sda_oe));

  p_sda_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(scl_fall_w || start_w || stop_w));

  p_no_double_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_oe && sda_oe));

  p_stretch_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !$past(ack_ready));

  p_stretch_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && ack_ready) |=> !scl_oe);

  p_valid_at_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(scl_rise_w));

  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind i2c_rx_target i2c_rx_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .ack_ready(ack_ready), .rx_valid(rx_valid), .scl_rise_w(scl_rise),
  .scl_fall_w(scl_fall), .start_w(start_ev), .stop_w(stop_ev)
);

// File: tb/tb_i2c_rx_target.sv
`timescale 1ns/1ps
module tb_i2c_rx_target;
  localparam int H = 16;
  localparam logic [6:0] OWN = 7'h52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic ack_ready = 1'b1;
  logic scl_oe, sda_oe, rx_valid;
  logic [7:0] rx_data;
  wire scl_bus = m_scl & ~scl_oe;
  wire sda_bus = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  i2c_rx_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN),
    .ack_ready(ack_ready), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  int checks = 0, errors = 0;
  logic [7:0] got[$];
  bit any_stretch = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: bus seen two clocks late, events from level history
  bit sc1 = 1, sc2 = 1, sc3 = 1, sd1 = 1, sd2 = 1, sd3 = 1;
  bit e_busy, e_first, e_addr, e_ack, e_dec, e_want, e_sda, e_valid;
  logic [7:0] sh, e_data;
  int cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      sc1 = 1; sc2 = 1; sc3 = 1; sd1 = 1; sd2 = 1; sd3 = 1;
      e_busy = 0; e_first = 0; e_addr = 0; e_ack = 0; e_dec = 0;
      e_want = 0; e_sda = 0; e_valid = 0; sh = 0; e_data = 0; cnt = 0;
    end else begin
      bit rs, fl, st, sp, w;
      rs = sc2 && !sc3; fl = !sc2 && sc3;
      st = sc2 && sc3 && !sd2 && sd3;
      sp = sc2 && sc3 && sd2 && !sd3;
      e_valid = 0;
      if (st || sp) begin
        e_busy = st; e_first = st; e_addr = 0; e_ack = 0; e_dec = 0;
        e_want = 0; e_sda = 0; cnt = 0;
      end else begin
        if (e_ack && !e_dec && ack_ready) begin e_dec = 1; e_sda = 1; end
        if (e_busy && rs && cnt < 8) begin
          sh = {sh[6:0], sd2}; cnt++;
        end else if (e_busy && cnt == 8 && !e_ack && fl) begin
          w = e_first ? (sh[7:1] == OWN && sh[0] == 1'b0) : e_addr;
          e_ack = 1; e_want = w; e_dec = !w || ack_ready; e_sda = w && ack_ready;
        end else if (e_ack && rs) begin
          if (e_first) begin e_addr = e_want; e_busy = e_want; e_first = 0; end
          else if (e_addr) begin e_valid = 1; e_data = sh; end
        end else if (e_ack && fl) begin
          e_ack = 0; e_dec = 0; e_want = 0; e_sda = 0; cnt = 0;
        end
      end
      sc3 = sc2; sc2 = sc1; sc1 = scl_bus;
      sd3 = sd2; sd2 = sd1; sd1 = sda_bus;
    end
  end

  // Every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk(rx_valid == e_valid, "R8 rx_valid per-cycle", rx_valid, e_valid);
      chk(rx_data == e_data, "R10 rx_data per-cycle", rx_data, e_data);
      chk(sda_oe == e_sda, "R4 sda_oe per-cycle", sda_oe, e_sda);
      chk(scl_oe == (e_ack && e_want && !e_dec), "R6 scl_oe per-cycle",
          scl_oe, e_ack && e_want && !e_dec);
      if (rx_valid) got.push_back(rx_data);
      if (scl_oe) any_stretch = 1;
    end
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic do_start();
    m_sda = 1; wt(H); m_scl = 1; wt(H); m_sda = 0; wt(H); m_scl = 0; wt(H);
  endtask

  task automatic do_stop();
    m_sda = 0; wt(H); m_scl = 1; wt(H); m_sda = 1; wt(H);
  endtask

  task automatic send_bit(input bit b, output bit seen);
    m_sda = b; wt(H); m_scl = 1;
    while (!scl_bus) wt(1);
    wt(H); seen = sda_bus; m_scl = 0; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) send_bit(v[i], s);
    send_bit(1'b1, s);
    acked = !s;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit a;
    int n;
    wt(5);
    chk(!scl_oe && !sda_oe && !rx_valid && rx_data == 0, "R1 reset outputs",
        {scl_oe, sda_oe, rx_valid, rx_data}, 0);
    rst_n = 1; wt(5);
    chk(!scl_oe && !sda_oe && !rx_valid && rx_data == 0, "R1 after reset",
        {scl_oe, sda_oe, rx_valid, rx_data}, 0);

    // Matched write, ready already high
    any_stretch = 0;
    do_start();
    send_byte(8'hA4, a); chk(a, "R4 matched address ACK", a, 1);
    send_byte(8'h5A, a); chk(a, "R8 data ACK", a, 1);
    send_byte(8'h01, a); chk(a, "R3 data ACK 0x01", a, 1);
    send_byte(8'h80, a); chk(a, "R3 data ACK 0x80", a, 1);
    do_stop();
    chk(got.size() == 3, "R8 byte count", got.size(), 3);
    if (got.size() == 3) begin
      chk(got[0] == 8'h5A, "R8 byte 0", got[0], 8'h5A);
      chk(got[1] == 8'h01, "R3 byte 0x01 MSB first", got[1], 8'h01);
      chk(got[2] == 8'h80, "R3 byte 0x80 MSB first", got[2], 8'h80);
    end
    chk(!any_stretch, "R7 no stretch when ready", any_stretch, 0);
    wt(40);
    chk(rx_data == 8'h80, "R10 rx_data held", rx_data, 8'h80);
    chk(!scl_oe && !sda_oe, "R2 idle after stop", {scl_oe, sda_oe}, 0);

    // Wrong address
    n = got.size();
    do_start();
    send_byte(8'h26, a); chk(!a, "R5 wrong address NACK", a, 0);
    send_byte(8'h77, a); chk(!a, "R5 data after mismatch NACK", a, 0);
    do_stop();
    chk(got.size() == n, "R5 no byte after mismatch", got.size(), n);

    // Read direction
    do_start();
    send_byte(8'hA5, a); chk(!a, "R5 read direction NACK", a, 0);
    do_stop();

    // Bits after STOP without a START
    send_byte(8'hA4, a); chk(!a, "R2 no ACK without START", a, 0);
    do_stop();
    chk(got.size() == n, "R2 no byte without START", got.size(), n);

    // Stretched acknowledge
    do_start();
    send_byte(8'hA4, a); chk(a, "R4 address ACK before stretch", a, 1);
    ack_ready = 0;
    fork
      send_byte(8'h3C, a);
      begin
        while (!scl_oe) wt(1);
        wt(100);
        chk(scl_oe && !scl_bus, "R6 SCL held low", scl_oe, 1);
        chk(!sda_oe, "R6 SDA released while stretched", sda_oe, 0);
        ack_ready = 1;
      end
    join
    chk(a, "R6 ACK after ready", a, 1);
    chk(got.size() == n + 1 && got[got.size()-1] == 8'h3C, "R6 stretched byte",
        got[got.size()-1], 8'h3C);
    do_stop();

    // Repeated START in the middle of a byte
    n = got.size();
    do_start();
    send_byte(8'hA4, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1, a);
    do_start();
    send_byte(8'hA4, a); chk(a, "R9 address ACK after repeated START", a, 1);
    send_byte(8'h96, a); chk(a, "R9 data ACK after repeated START", a, 1);
    do_stop();
    chk(got.size() == n + 1, "R9 partial byte dropped", got.size(), n + 1);
    chk(got[got.size()-1] == 8'h96, "R9 new byte", got[got.size()-1], 8'h96);

    wt(20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule